// File: doc/BRIEF.md
# Out-of-Order Issue Scheduler

This block is the instruction buffer that sits between dispatch and the execution units of an out-of-order core. Each dispatched instruction carries source tags with availability flags, a destination tag, an execution latency, a resource-group code and an identifier from the retire logic. The block stores it in a free slot and holds it in one of three states: waiting for operands, ready to issue, or executing. Execution datapaths and register values are not part of this block.

Every cycle, write-back broadcasts of destination tags wake up the waiting entries that depend on them. Each resource group issues its oldest ready entry to one of its idle units. The unit is picked round-robin. An executing entry counts its latency down. At zero it drives its unit's write-back port, which both completes the entry towards retire and broadcasts its tag. The block also reports when it is full, how many instructions issued this cycle, and its current and peak occupancy.

Top module: `issue_sched`

## Requirements
- R1: After reset the buffer is empty: occupancy, peak occupancy and issue count are 0, full is low and no write-back port is valid.
- R2: An instruction accepted in cycle d with all sources available issues in cycle d+1 at the earliest, never in cycle d. Its write-back is visible in cycle d+1+L for latency L, and a latency of 0 behaves as 1.
- R3: A waiting entry whose last missing source tag is broadcast in cycle w becomes ready in cycle w+1 and can issue in that cycle.
- R4: A source whose tag is broadcast in the same cycle the instruction is dispatched counts as available at dispatch.
- R5: Within a resource group, at most one entry issues per cycle, and among ready entries the one dispatched earliest wins, whatever slot it occupies.
- R6: Group g owns units g*UNITS_PER_GRP to g*UNITS_PER_GRP+UNITS_PER_GRP-1. The group picks its unit round-robin, starting from the unit after the one it last used and skipping busy units.
- R7: A unit stays busy from issue until its write-back cycle. In the write-back cycle it may accept the next issue.
- R8: Write-back port u is valid for exactly one cycle per instruction executed on unit u, and carries that instruction's destination tag and identifier.
- R9: Full is high exactly when all DEPTH slots are occupied. A dispatch presented while full is dropped and never executes.
- R10: Occupancy equals the number of slots in use. Peak occupancy is the largest occupancy seen since reset and never decreases.
- R11: The issue count equals the number of groups that issue in the cycle. Two groups can issue together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch request |
| disp_src_tag_i | input | NUM_SRC*TAG_W | Source tags, source s at bits s*TAG_W |
| disp_src_rdy_i | input | NUM_SRC | Source s already available |
| disp_dst_tag_i | input | TAG_W | Destination tag |
| disp_lat_i | input | LAT_W | Execution latency in cycles |
| disp_grp_i | input | GRP_W | Resource group code |
| disp_id_i | input | ID_W | Retire identifier |
| full_o | output | 1 | All slots occupied |
| issue_cnt_o | output | ISS_W | Instructions issued this cycle |
| wb_valid_o | output | NUM_UNITS | Write-back valid per unit |
| wb_tag_o | output | NUM_UNITS*TAG_W | Broadcast tag per unit |
| wb_id_o | output | NUM_UNITS*ID_W | Completed identifier per unit |
| occ_o | output | OCC_W | Current occupancy |
| peak_o | output | OCC_W | Peak occupancy since reset |

## Verification
Two events can meet in one cycle: dispatch of a consumer and the write-back broadcast of the tag it reads. If the consumer does not capture that broadcast, it waits forever. The bench provokes this by timing idle cycles so that the consumer is dispatched exactly in the producer's write-back cycle. It then judges the outcome by the consumer's write-back cycle, which must come two cycles later for latency 1. A second collision is a unit finishing in the same cycle that a queued entry needs it. This case is judged by the queued entry's issue cycle and unit number.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_RDY  = 2'd2,
    SLOT_EXEC = 2'd3
  } slot_st_e;

  function automatic int w1(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sched_age_matrix.sv
module sched_age_matrix #(
  parameter int DEPTH   = 4,
  parameter int NUM_REQ = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [DEPTH-1:0]         alloc_oh_i,
  input  logic [DEPTH-1:0]         live_i,
  input  logic [NUM_REQ*DEPTH-1:0] req_i,
  output logic [NUM_REQ*DEPTH-1:0] gnt_o
);
  // older_q[j][i]: entry j was dispatched before entry i
  logic [DEPTH-1:0] older_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) older_q[i] <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        if (alloc_oh_i[k]) begin
          older_q[k] <= '0;
          for (int j = 0; j < DEPTH; j++)
            if (j != k) older_q[j][k] <= live_i[j];
        end
      end
    end
  end

  always_comb begin
    gnt_o = '0;
    for (int r = 0; r < NUM_REQ; r++) begin
      for (int i = 0; i < DEPTH; i++) begin
        logic blocked;
        blocked = 1'b0;
        for (int j = 0; j < DEPTH; j++)
          if (req_i[r*DEPTH+j] && older_q[j][i]) blocked = 1'b1;
        gnt_o[r*DEPTH+i] = req_i[r*DEPTH+i] && !blocked;
      end
    end
  end
endmodule

// File: rtl/sched_rr_pick.sv
module sched_rr_pick #(
  parameter  int N  = 2,
  localparam int IW = sched_pkg::w1(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  avail_i,
  input  logic          take_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] ptr_q;

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int j;
      j = (int'(ptr_q) + k) % N;
      if (avail_i[j]) begin
        any_o = 1'b1;
        idx_o = IW'(j);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (take_i) ptr_q <= (int'(idx_o) == N - 1) ? '0 : idx_o + IW'(1);
  end
endmodule

// File: rtl/issue_sched.sv
module issue_sched import sched_pkg::*; #(
  parameter  int DEPTH         = 4,
  parameter  int NUM_SRC       = 2,
  parameter  int TAG_W         = 4,
  parameter  int LAT_W         = 3,
  parameter  int NUM_GRP       = 2,
  parameter  int UNITS_PER_GRP = 2,
  parameter  int ID_W          = 4,
  localparam int NUM_UNITS     = NUM_GRP * UNITS_PER_GRP,
  localparam int GRP_W         = w1(NUM_GRP),
  localparam int UNIT_W        = w1(NUM_UNITS),
  localparam int UIDX_W        = w1(UNITS_PER_GRP),
  localparam int OCC_W         = $clog2(DEPTH + 1),
  localparam int ISS_W         = $clog2(NUM_GRP + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       disp_valid_i,
  input  logic [NUM_SRC*TAG_W-1:0]   disp_src_tag_i,
  input  logic [NUM_SRC-1:0]         disp_src_rdy_i,
  input  logic [TAG_W-1:0]           disp_dst_tag_i,
  input  logic [LAT_W-1:0]           disp_lat_i,
  input  logic [GRP_W-1:0]           disp_grp_i,
  input  logic [ID_W-1:0]            disp_id_i,
  output logic                       full_o,
  output logic [ISS_W-1:0]           issue_cnt_o,
  output logic [NUM_UNITS-1:0]       wb_valid_o,
  output logic [NUM_UNITS*TAG_W-1:0] wb_tag_o,
  output logic [NUM_UNITS*ID_W-1:0]  wb_id_o,
  output logic [OCC_W-1:0]           occ_o,
  output logic [OCC_W-1:0]           peak_o
);
  slot_st_e           st_q   [DEPTH];
  logic [TAG_W-1:0]   src_q  [DEPTH][NUM_SRC];
  logic [NUM_SRC-1:0] srdy_q [DEPTH];
  logic [TAG_W-1:0]   dst_q  [DEPTH];
  logic [LAT_W-1:0]   cnt_q  [DEPTH];
  logic [GRP_W-1:0]   grp_q  [DEPTH];
  logic [ID_W-1:0]    id_q   [DEPTH];
  logic [UNIT_W-1:0]  unit_q [DEPTH];
  logic [OCC_W-1:0]   peak_q;

  logic [DEPTH-1:0]         live, done, alloc_oh, issue_oh;
  logic [UNIT_W-1:0]        issue_unit [DEPTH];
  logic [NUM_SRC-1:0]       wake [DEPTH];
  logic [NUM_SRC-1:0]       disp_rdy;
  logic [NUM_UNITS-1:0]     unit_busy;
  logic [NUM_GRP*DEPTH-1:0] req, gnt;
  logic [NUM_GRP-1:0]       take, unit_any;
  logic [UIDX_W-1:0]        pick_idx [NUM_GRP];
  logic [LAT_W-1:0]         lat_eff;

  // completion: countdown at 1 means this is the write-back cycle
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      live[i] = st_q[i] != SLOT_FREE;
      done[i] = (st_q[i] == SLOT_EXEC) && (cnt_q[i] == LAT_W'(1));
    end
  end

  always_comb begin
    wb_valid_o = '0;
    wb_tag_o   = '0;
    wb_id_o    = '0;
    unit_busy  = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (st_q[i] == SLOT_EXEC && unit_q[i] == UNIT_W'(u)) begin
          if (done[i]) begin
            wb_valid_o[u]                 = 1'b1;
            wb_tag_o[u*TAG_W +: TAG_W]    = dst_q[i];
            wb_id_o[u*ID_W +: ID_W]       = id_q[i];
          end else begin
            unit_busy[u] = 1'b1;
          end
        end
      end
    end
  end

  // tag wake-up for stored entries and for the incoming instruction
  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) begin
      disp_rdy[s] = disp_src_rdy_i[s];
      for (int u = 0; u < NUM_UNITS; u++)
        if (wb_valid_o[u] && wb_tag_o[u*TAG_W +: TAG_W] == disp_src_tag_i[s*TAG_W +: TAG_W])
          disp_rdy[s] = 1'b1;
    end
    for (int i = 0; i < DEPTH; i++) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        wake[i][s] = 1'b0;
        for (int u = 0; u < NUM_UNITS; u++)
          if (wb_valid_o[u] && wb_tag_o[u*TAG_W +: TAG_W] == src_q[i][s])
            wake[i][s] = 1'b1;
      end
    end
  end

  always_comb begin
    for (int g = 0; g < NUM_GRP; g++)
      for (int i = 0; i < DEPTH; i++)
        req[g*DEPTH+i] = (st_q[i] == SLOT_RDY) && (grp_q[i] == GRP_W'(g));
  end

  sched_age_matrix #(.DEPTH(DEPTH), .NUM_REQ(NUM_GRP)) u_age (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .alloc_oh_i(alloc_oh),
    .live_i    (live),
    .req_i     (req),
    .gnt_o     (gnt)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic [UNITS_PER_GRP-1:0] avail;
    assign avail   = ~unit_busy[g*UNITS_PER_GRP +: UNITS_PER_GRP];
    assign take[g] = unit_any[g] && (|gnt[g*DEPTH +: DEPTH]);

    sched_rr_pick #(.N(UNITS_PER_GRP)) u_rr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .avail_i(avail),
      .take_i (take[g]),
      .any_o  (unit_any[g]),
      .idx_o  (pick_idx[g])
    );
  end

  always_comb begin
    issue_oh    = '0;
    issue_cnt_o = '0;
    for (int i = 0; i < DEPTH; i++) issue_unit[i] = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      issue_cnt_o = issue_cnt_o + ISS_W'(take[g]);
      for (int i = 0; i < DEPTH; i++) begin
        if (take[g] && gnt[g*DEPTH+i]) begin
          issue_oh[i]   = 1'b1;
          issue_unit[i] = UNIT_W'(g * UNITS_PER_GRP + int'(pick_idx[g]));
        end
      end
    end
  end

  // lowest free slot takes the dispatch
  always_comb begin
    logic found;
    found    = 1'b0;
    alloc_oh = '0;
    occ_o    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      occ_o = occ_o + OCC_W'(live[i]);
      if (!found && !live[i]) begin
        alloc_oh[i] = disp_valid_i;
        found       = 1'b1;
      end
    end
    full_o = !found;
  end

  assign lat_eff = (disp_lat_i == '0) ? LAT_W'(1) : disp_lat_i;
  assign peak_o  = (peak_q > occ_o) ? peak_q : occ_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      peak_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        st_q[i]   <= SLOT_FREE;
        srdy_q[i] <= '0;
        dst_q[i]  <= '0;
        cnt_q[i]  <= '0;
        grp_q[i]  <= '0;
        id_q[i]   <= '0;
        unit_q[i] <= '0;
        for (int s = 0; s < NUM_SRC; s++) src_q[i][s] <= '0;
      end
    end else begin
      peak_q <= peak_o;
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc_oh[i]) begin
          st_q[i]   <= (&disp_rdy) ? SLOT_RDY : SLOT_WAIT;
          srdy_q[i] <= disp_rdy;
          dst_q[i]  <= disp_dst_tag_i;
          cnt_q[i]  <= lat_eff;
          grp_q[i]  <= disp_grp_i;
          id_q[i]   <= disp_id_i;
          unit_q[i] <= '0;
          for (int s = 0; s < NUM_SRC; s++) src_q[i][s] <= disp_src_tag_i[s*TAG_W +: TAG_W];
        end else begin
          unique case (st_q[i])
            SLOT_WAIT: begin
              srdy_q[i] <= srdy_q[i] | wake[i];
              if (&(srdy_q[i] | wake[i])) st_q[i] <= SLOT_RDY;
            end
            SLOT_RDY: begin
              if (issue_oh[i]) begin
                st_q[i]   <= SLOT_EXEC;
                unit_q[i] <= issue_unit[i];
              end
            end
            SLOT_EXEC: begin
              if (done[i]) st_q[i] <= SLOT_FREE;
              else         cnt_q[i] <= cnt_q[i] - LAT_W'(1);
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
  parameter int DEPTH     = 4,
  parameter int NUM_GRP   = 2,
  parameter int NUM_UNITS = 4,
  parameter int OCC_W     = 3,
  parameter int ISS_W     = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 disp_valid_i,
  input logic                 full_o,
  input logic [ISS_W-1:0]     issue_cnt_o,
  input logic [NUM_UNITS-1:0] wb_valid_o,
  input logic [OCC_W-1:0]     occ_o,
  input logic [OCC_W-1:0]     peak_o
);
  assert_empty_no_issue_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_o == '0 |-> issue_cnt_o == '0);

  assert_idle_no_wb_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(occ_o) == '0 |-> wb_valid_o == '0);

  assert_full_means_all_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> int'(occ_o) == DEPTH);

  assert_full_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && disp_valid_i) |=> int'(occ_o) <= int'($past(occ_o)));

  assert_peak_cover_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    peak_o >= occ_o);

  assert_peak_mono_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    peak_o >= $past(peak_o));

  assert_occ_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(occ_o) <= int'($past(occ_o)) + 1);

  assert_issue_bound_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(issue_cnt_o) <= NUM_GRP && issue_cnt_o <= occ_o);
endmodule

bind issue_sched sched_checker #(
  .DEPTH(DEPTH), .NUM_GRP(NUM_GRP), .NUM_UNITS(NUM_UNITS), .OCC_W(OCC_W), .ISS_W(ISS_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .disp_valid_i(disp_valid_i),
  .full_o      (full_o),
  .issue_cnt_o (issue_cnt_o),
  .wb_valid_o  (wb_valid_o),
  .occ_o       (occ_o),
  .peak_o      (peak_o)
);

// File: tb/sim_issue_sched.sv
`timescale 1ns/1ps
module sim_issue_sched;
  localparam int DEPTH = 4, NSRC = 2, TAG_W = 4, LAT_W = 3, NG = 2, UPG = 2, ID_W = 4;
  localparam int NU = NG * UPG;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic                  disp_valid = 1'b0;
  logic [NSRC*TAG_W-1:0] disp_src_tag = '0;
  logic [NSRC-1:0]       disp_src_rdy = '0;
  logic [TAG_W-1:0]      disp_dst = '0;
  logic [LAT_W-1:0]      disp_lat = '0;
  logic [0:0]            disp_grp = '0;
  logic [ID_W-1:0]       disp_id = '0;
  logic                  full;
  logic [1:0]            issue_cnt;
  logic [NU-1:0]         wb_valid;
  logic [NU*TAG_W-1:0]   wb_tag;
  logic [NU*ID_W-1:0]    wb_id;
  logic [2:0]            occ, peak;

  issue_sched #(.DEPTH(DEPTH), .NUM_SRC(NSRC), .TAG_W(TAG_W), .LAT_W(LAT_W),
                .NUM_GRP(NG), .UNITS_PER_GRP(UPG), .ID_W(ID_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .disp_valid_i(disp_valid),
    .disp_src_tag_i(disp_src_tag), .disp_src_rdy_i(disp_src_rdy),
    .disp_dst_tag_i(disp_dst), .disp_lat_i(disp_lat), .disp_grp_i(disp_grp),
    .disp_id_i(disp_id), .full_o(full), .issue_cnt_o(issue_cnt),
    .wb_valid_o(wb_valid), .wb_tag_o(wb_tag), .wb_id_o(wb_id),
    .occ_o(occ), .peak_o(peak)
  );

  int cyc = 0, tests = 0, fails = 0;
  int wb_cyc [16], wb_unit [16], wb_tg [16], wb_n [16];
  int ic_log [4096];

  // outputs sampled at the falling edge, inputs driven 1 ns after the rising edge
  always @(negedge clk) begin
    int id;
    cyc++;
    ic_log[cyc % 4096] = int'(issue_cnt);
    for (int u = 0; u < NU; u++) begin
      if (wb_valid[u]) begin
        id = int'(wb_id[u*ID_W +: ID_W]);
        wb_cyc[id]  = cyc;
        wb_unit[id] = u;
        wb_tg[id]   = int'(wb_tag[u*TAG_W +: TAG_W]);
        wb_n[id]++;
      end
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 16; i++) begin
      wb_cyc[i] = -1; wb_unit[i] = -1; wb_tg[i] = -1; wb_n[i] = 0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic disp(input int id, input int g, input int lat, input int dst,
                      input int s0, input int r0, input int s1, input int r1,
                      output int d);
    disp_valid   = 1'b1;
    disp_id      = ID_W'(id);
    disp_grp     = 1'(g);
    disp_lat     = LAT_W'(lat);
    disp_dst     = TAG_W'(dst);
    disp_src_tag = {TAG_W'(s1), TAG_W'(s0)};
    disp_src_rdy = {1'(r1), 1'(r0)};
    d = cyc + 1;
    @(posedge clk); #1;
    disp_valid = 1'b0;
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    tests++; fails++;
    $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
    report();
  end

  initial begin
    int d, d6, dp, x;
    clr();
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 occ", int'(occ), 0);
    chk("R1 peak", int'(peak), 0);
    chk("R1 full", int'(full), 0);
    chk("R1 wb", int'(wb_valid), 0);
    chk("R1 issue", int'(issue_cnt), 0);
    rst_ni = 1'b1;
    idle(2);

    // R2 R8: lone ready op, latency 3
    disp(1, 0, 3, 7, 0, 1, 0, 1, d);
    chk("R2 issue next cycle", int'(issue_cnt), 1);
    idle(6);
    chk("R2 no issue in dispatch cycle", ic_log[d % 4096], 0);
    chk("R2 wb cycle", wb_cyc[1], d + 4);
    chk("R6 first unit", wb_unit[1], 0);
    chk("R8 wb tag", wb_tg[1], 7);
    chk("R8 single pulse", wb_n[1], 1);
    chk("R10 drained", int'(occ), 0);

    // R2 latency 0 acts as 1
    disp(2, 1, 0, 3, 0, 1, 0, 1, d);
    idle(4);
    chk("R2 lat0 wb", wb_cyc[2], d + 2);
    chk("R6 group1 base unit", wb_unit[2], 2);

    // R6 round robin in both groups
    disp(3, 1, 1, 3, 0, 1, 0, 1, d);
    idle(3);
    disp(4, 1, 1, 3, 0, 1, 0, 1, d);
    idle(3);
    disp(5, 0, 1, 3, 0, 1, 0, 1, d);
    idle(3);
    chk("R6 rr g1 second", wb_unit[3], 3);
    chk("R6 rr g1 wrap", wb_unit[4], 2);
    chk("R6 rr g0 advance", wb_unit[5], 1);

    // R7 both group-0 units busy, third op takes unit freed in its wb cycle
    disp(6, 0, 5, 3, 0, 1, 0, 1, d6);
    disp(7, 0, 5, 3, 0, 1, 0, 1, x);
    disp(8, 0, 5, 3, 0, 1, 0, 1, x);
    idle(14);
    chk("R7 first wb", wb_cyc[6], d6 + 6);
    chk("R7 second wb", wb_cyc[7], d6 + 7);
    chk("R7 no unit no issue", ic_log[(d6 + 3) % 4096], 0);
    chk("R7 reuse in wb cycle", wb_cyc[8], d6 + 11);
    chk("R7 reused unit", wb_unit[8], 0);
    chk("R10 peak three", int'(peak), 3);

    // R3 R5 R11: older waiter in higher slot, shared wake tag 11
    clr();
    disp(9, 1, 2, 1, 0, 1, 0, 1, x);
    disp(10, 0, 1, 2, 11, 0, 0, 1, x);
    idle(3);
    disp(11, 0, 1, 3, 11, 0, 0, 1, x);
    disp(12, 1, 2, 4, 0, 1, 11, 0, x);
    disp(13, 1, 1, 11, 0, 1, 0, 1, dp);
    chk("R9 full at four", int'(full), 1);
    chk("R10 peak four", int'(peak), 4);
    idle(8);
    chk("R8 producer tag", wb_tg[13], 11);
    chk("R3 producer wb", wb_cyc[13], dp + 2);
    chk("R11 dual issue", ic_log[(dp + 3) % 4096], 2);
    chk("R5 older first", wb_cyc[10], dp + 4);
    chk("R5 younger next", wb_cyc[11], dp + 5);
    chk("R5 one per group", ic_log[(dp + 4) % 4096], 1);
    chk("R3 other group wake", wb_cyc[12], dp + 5);

    // R4 consumer dispatched in producer's wb cycle
    clr();
    disp(14, 0, 2, 5, 0, 1, 0, 1, d);
    idle(2);
    disp(15, 1, 1, 6, 5, 0, 0, 1, x);
    idle(5);
    chk("R4 dispatch aligned", x, d + 3);
    chk("R4 bypass wake", wb_cyc[15], d + 5);

    // R9 R10 fill, drop while full, drain
    clr();
    disp(1, 0, 7, 1, 0, 1, 0, 1, d);
    disp(2, 1, 7, 1, 0, 1, 0, 1, x);
    disp(3, 0, 7, 1, 0, 1, 0, 1, x);
    disp(4, 1, 7, 1, 0, 1, 0, 1, x);
    chk("R9 full", int'(full), 1);
    chk("R10 occ four", int'(occ), 4);
    disp(5, 0, 1, 1, 0, 1, 0, 1, x);
    chk("R9 dropped occ", int'(occ), 4);
    idle(20);
    chk("R9 dropped never runs", wb_n[5], 0);
    chk("R9 first of fill done", wb_n[1], 1);
    chk("R9 last of fill done", wb_n[4], 1);
    chk("R9 full clears", int'(full), 0);
    chk("R10 empty", int'(occ), 0);
    chk("R10 peak held", int'(peak), 4);
    report();
  end
endmodule